// File: doc/BRIEF.md
# Fractional UART Bit-Timing Generator

This block produces the timing strobes that a serial transmitter and receiver share. A prescaler counts pulses of an already selected base clock enable and, after a programmed divider value plus one of them, emits a single-cycle transfer tick (the RT tick). A second counter groups these ticks into bit periods. It flags the tick that closes each bit and the tick that falls in the middle of each bit, where a receiver samples the line.

A 3-bit length select sets the number of ticks in one bit. Three codes give fixed lengths of 15, 16 or 17 ticks. Two codes switch between neighbouring lengths on every bit, which gives an average of 15.5 or 16.5 ticks and lets a slow base clock reach standard rates more closely. A frame-start pulse restarts the timing and the alternation. Divider and select values are captured only at bit boundaries, so a bit in progress always keeps the length it started with.

Top module: `uart_bit_timer`

## Requirements
- R1: With `en` high, `rt_tick` pulses for exactly one cycle once every `div_val`+1 cycles in which `base_tick` is high. When `base_tick` is held high, the first pulse comes `div_val`+1 cycles after a frame start is released.
- R2: Select code 3'b000 gives 16 RT ticks per bit, 3'b010 gives 15 and 3'b100 gives 17. `bit_strobe` is high together with the `rt_tick` that closes each bit.
- R3: Code 3'b001 alternates bit lengths 16, 17, 16, 17 and code 3'b011 alternates 15, 16, 15, 16. The first bit after a frame start or an enable always uses the shorter length.
- R4: Codes 3'b101, 3'b110 and 3'b111 give 16 ticks per bit.
- R5: `mid_strobe` is high together with tick number floor(L/2) of a bit of L ticks, counting the ticks of the bit from 1. It is never high in the same cycle as `bit_strobe`.
- R6: A `frame_start` pulse clears the prescaler, the in-bit tick count and the alternation phase, and captures the current divider and select. No strobe is issued in the cycle after it, and the next bit runs its full length.
- R7: A change of `div_val` or `len_sel` during a bit does not alter that bit's length or tick spacing. It applies from the next bit on.
- R8: While `en` is low, all counters stay at zero and no strobe is issued. After `en` rises, the first `rt_tick` follows `div_val`+1 base ticks.
- R9: During and right after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Synchronous enable for the whole timer |
| frame_start | input | 1 | Restarts bit timing and the alternation phase |
| base_tick | input | 1 | Enable pulse from the selected base clock |
| div_val | input | DIV_W (8) | Prescaler divider; tick period is div_val+1 base ticks |
| len_sel | input | 3 | Bit length select code |
| rt_tick | output | 1 | Transfer base tick, one cycle wide |
| bit_strobe | output | 1 | Last tick of each bit |
| mid_strobe | output | 1 | Mid-bit sample tick |

## Verification
Each fixed code is run with a different divider. The measured tick spacing and tick count per bit therefore separate a prescaler error from a length decoding error. The alternating codes are run over several bits to tell the order of the two lengths apart from their values. A frame start is then issued after an odd number of bits, which shows whether the phase really restarts. A divider of zero, a base tick that is high only every other cycle, and select and divider changes made in the middle of a bit each test a timing path that a steady pattern leaves unexercised.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
    localparam int SEL_W   = 3;
    localparam int NOM_LEN = 16;
    localparam int LEN_W   = $clog2(NOM_LEN + 2);

    localparam logic [SEL_W-1:0] SEL_NOM    = 3'b000;
    localparam logic [SEL_W-1:0] SEL_ALT_UP = 3'b001;
    localparam logic [SEL_W-1:0] SEL_SHORT  = 3'b010;
    localparam logic [SEL_W-1:0] SEL_ALT_DN = 3'b011;
    localparam logic [SEL_W-1:0] SEL_LONG   = 3'b100;
endpackage

// File: rtl/ubt_prescaler.sv
module ubt_prescaler #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div_lim,
    output logic             tick_ev
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        tick_ev = 1'b0;
        if (!run || clear) begin
            st_d.cnt = '0;
        end else if (base_tick) begin
            if (st_q.cnt >= div_lim) begin
                tick_ev  = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ubt_len_dec.sv
module ubt_len_dec
    import ubt_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             phase,
    output logic [LEN_W-1:0] bit_len
);
    localparam logic [LEN_W-1:0] L_NOM   = LEN_W'(NOM_LEN);
    localparam logic [LEN_W-1:0] L_SHORT = LEN_W'(NOM_LEN - 1);
    localparam logic [LEN_W-1:0] L_LONG  = LEN_W'(NOM_LEN + 1);

    always_comb begin
        case (sel)
            SEL_SHORT:  bit_len = L_SHORT;
            SEL_LONG:   bit_len = L_LONG;
            SEL_ALT_UP: bit_len = phase ? L_LONG : L_NOM;
            SEL_ALT_DN: bit_len = phase ? L_NOM : L_SHORT;
            default:    bit_len = L_NOM;
        endcase
    end
endmodule

// File: rtl/ubt_bit_ctr.sv
module ubt_bit_ctr
    import ubt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick_ev,
    input  logic [DIV_W-1:0] div_in,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [LEN_W-1:0] bit_len,
    output logic [DIV_W-1:0] div_act,
    output logic [SEL_W-1:0] sel_act,
    output logic             phase,
    output logic             rt_tick,
    output logic             bit_strobe,
    output logic             mid_strobe
);
    typedef struct packed {
        logic [LEN_W-1:0] tcnt;
        logic             phase;
        logic [DIV_W-1:0] div;
        logic [SEL_W-1:0] sel;
        logic             rt;
        logic             bs;
        logic             ms;
    } bit_st_t;

    bit_st_t          st_d, st_q;
    logic [LEN_W-1:0] tick_num;
    logic [LEN_W-1:0] half_len;

    assign tick_num = st_q.tcnt + LEN_W'(1);
    assign half_len = bit_len >> 1;

    always_comb begin
        st_d    = st_q;
        st_d.rt = 1'b0;
        st_d.bs = 1'b0;
        st_d.ms = 1'b0;
        if (!run || clear) begin
            st_d.tcnt  = '0;
            st_d.phase = 1'b0;
            st_d.div   = div_in;
            st_d.sel   = sel_in;
        end else if (tick_ev) begin
            st_d.rt = 1'b1;
            if (tick_num == half_len) st_d.ms = 1'b1;
            if (tick_num >= bit_len) begin
                st_d.bs    = 1'b1;
                st_d.tcnt  = '0;
                st_d.phase = ~st_q.phase;
                st_d.div   = div_in;
                st_d.sel   = sel_in;
            end else begin
                st_d.tcnt = tick_num;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_act    = st_q.div;
    assign sel_act    = st_q.sel;
    assign phase      = st_q.phase;
    assign rt_tick    = st_q.rt;
    assign bit_strobe = st_q.bs;
    assign mid_strobe = st_q.ms;
endmodule

// File: rtl/uart_bit_timer.sv
module uart_bit_timer
    import ubt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             frame_start,
    input  logic             base_tick,
    input  logic [DIV_W-1:0] div_val,
    input  logic [SEL_W-1:0] len_sel,
    output logic             rt_tick,
    output logic             bit_strobe,
    output logic             mid_strobe
);
    logic             tick_ev;
    logic [DIV_W-1:0] div_act;
    logic [SEL_W-1:0] sel_act;
    logic             phase;
    logic [LEN_W-1:0] bit_len;

    ubt_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (en),
        .clear     (frame_start),
        .base_tick (base_tick),
        .div_lim   (div_act),
        .tick_ev   (tick_ev)
    );

    ubt_len_dec u_dec (
        .sel     (sel_act),
        .phase   (phase),
        .bit_len (bit_len)
    );

    ubt_bit_ctr #(.DIV_W(DIV_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en),
        .clear      (frame_start),
        .tick_ev    (tick_ev),
        .div_in     (div_val),
        .sel_in     (len_sel),
        .bit_len    (bit_len),
        .div_act    (div_act),
        .sel_act    (sel_act),
        .phase      (phase),
        .rt_tick    (rt_tick),
        .bit_strobe (bit_strobe),
        .mid_strobe (mid_strobe)
    );
endmodule

// File: rtl/ubt_checker.sv
module ubt_checker (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic frame_start,
    input logic base_tick,
    input logic rt_tick,
    input logic bit_strobe,
    input logic mid_strobe
);
    // R2
    bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> rt_tick);

    // R5
    mid_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mid_strobe |-> rt_tick);

    // R5
    mid_not_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mid_strobe && bit_strobe));

    // R1
    tick_needs_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rt_tick |-> $past(base_tick && en));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(rt_tick || bit_strobe || mid_strobe));

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !(rt_tick || bit_strobe || mid_strobe));
endmodule

bind uart_bit_timer ubt_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .frame_start (frame_start),
    .base_tick   (base_tick),
    .rt_tick     (rt_tick),
    .bit_strobe  (bit_strobe),
    .mid_strobe  (mid_strobe)
);

// File: tb/uart_bit_timer_test.sv
`timescale 1ns/1ps
module uart_bit_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       frame_start = 1'b0;
    logic       base_tick = 1'b1;
    logic [7:0] div_val = 8'd0;
    logic [2:0] len_sel = 3'b000;
    logic       rt_tick, bit_strobe, mid_strobe;

    int checks = 0;
    int bad = 0;
    bit finished = 1'b0;

    int lens[16];
    int mids[16];
    int lastper[16];
    int per_bad;
    logic [2:0] new_sel;
    logic [7:0] new_div;

    always #4 clk = ~clk;

    uart_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
        .base_tick(base_tick), .div_val(div_val), .len_sel(len_sel),
        .rt_tick(rt_tick), .bit_strobe(bit_strobe), .mid_strobe(mid_strobe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic restart();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Gather nbits bit lengths; optional input change after change_at ticks of bit 0.
    task automatic collect(input int nbits, input int period, input int change_at, input bit gate);
        int ticks = 0;
        int since = 0;
        int got = 0;
        int cyc = 0;
        bit seen = 1'b0;
        per_bad = 0;
        for (int i = 0; i < 16; i++) begin mids[i] = 0; lens[i] = 0; lastper[i] = 0; end
        while (got < nbits && cyc < 6000) begin
            @(negedge clk);
            cyc++;
            since++;
            if (rt_tick) begin
                ticks++;
                if (period > 0 && (seen || !gate) && since != period) per_bad++;
                seen = 1'b1;
                if (mid_strobe) mids[got] = ticks;
                if (bit_strobe) begin
                    lens[got] = ticks;
                    lastper[got] = since;
                    got++;
                    ticks = 0;
                end else if (got == 0 && change_at > 0 && ticks == change_at) begin
                    len_sel = new_sel;
                    div_val = new_div;
                end
                since = 0;
            end
            if (gate) base_tick = ~base_tick;
        end
        base_tick = 1'b1;
    endtask

    task automatic test_fixed(input logic [2:0] sel, input logic [7:0] dv, input int exp_len, input string req);
        len_sel = sel; div_val = dv;
        restart();
        collect(3, dv + 1, 0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            chk(lens[i] == exp_len, req, lens[i], exp_len);
            chk(mids[i] == exp_len / 2, "R5 mid position", mids[i], exp_len / 2);
        end
        chk(per_bad == 0, "R1 tick spacing", per_bad, 0);
    endtask

    task automatic test_alt(input logic [2:0] sel, input int short_len, input string req);
        len_sel = sel; div_val = 8'd1;
        restart();
        collect(4, 2, 0, 1'b0);
        for (int i = 0; i < 4; i++) begin
            chk(lens[i] == short_len + (i % 2), req, lens[i], short_len + (i % 2));
            chk(mids[i] == (short_len + (i % 2)) / 2, "R5 mid alt", mids[i], (short_len + (i % 2)) / 2);
        end
    endtask

    task automatic test_restart_phase();
        len_sel = 3'b011; div_val = 8'd1;
        restart();
        collect(3, 2, 0, 1'b0);
        restart();
        collect(1, 2, 0, 1'b0);
        chk(lens[0] == 15, "R6 phase cleared by frame start", lens[0], 15);
        len_sel = 3'b000;
        restart();
        repeat (11) @(negedge clk);
        restart();
        collect(1, 2, 0, 1'b0);
        chk(lens[0] == 16, "R6 tick count cleared by frame start", lens[0], 16);
        chk(per_bad == 0, "R6 prescaler cleared by frame start", per_bad, 0);
    endtask

    task automatic test_midbit_change();
        len_sel = 3'b000; div_val = 8'd3;
        new_sel = 3'b010; new_div = 8'd1;
        restart();
        collect(2, 0, 5, 1'b0);
        chk(lens[0] == 16, "R7 current bit length kept", lens[0], 16);
        chk(lastper[0] == 4, "R7 current bit divider kept", lastper[0], 4);
        chk(lens[1] == 15, "R7 new length next bit", lens[1], 15);
        chk(lastper[1] == 2, "R7 new divider next bit", lastper[1], 2);
    endtask

    task automatic test_disable();
        int strobes = 0;
        int wait_n = 0;
        len_sel = 3'b000; div_val = 8'd2;
        restart();
        repeat (20) @(negedge clk);
        en = 1'b0;
        div_val = 8'd5;
        repeat (40) begin
            @(negedge clk);
            if (rt_tick || bit_strobe || mid_strobe) strobes++;
        end
        chk(strobes == 0, "R8 quiet while disabled", strobes, 0);
        en = 1'b1;
        while (!rt_tick && wait_n < 100) begin @(negedge clk); wait_n++; end
        chk(wait_n == 6, "R8 first tick after enable", wait_n, 6);
    endtask

    task automatic test_gated_base();
        len_sel = 3'b000; div_val = 8'd3;
        restart();
        collect(2, 8, 0, 1'b1);
        chk(per_bad == 0, "R1 counts base ticks only", per_bad, 0);
        chk(lens[1] == 16, "R1 gated base bit length", lens[1], 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({rt_tick, bit_strobe, mid_strobe} == 3'b000, "R9 outputs low in reset", {rt_tick, bit_strobe, mid_strobe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({rt_tick, bit_strobe, mid_strobe} == 3'b000, "R9 outputs low after reset", {rt_tick, bit_strobe, mid_strobe}, 0);
        en = 1'b1;
        test_fixed(3'b000, 8'd3, 16, "R2 code 000");
        test_fixed(3'b010, 8'd2, 15, "R2 code 010");
        test_fixed(3'b100, 8'd0, 17, "R2 code 100");
        test_fixed(3'b101, 8'd1, 16, "R4 code 101");
        test_fixed(3'b111, 8'd4, 16, "R4 code 111");
        test_fixed(3'b110, 8'd0, 16, "R4 code 110");
        test_alt(3'b011, 15, "R3 code 011");
        test_alt(3'b001, 16, "R3 code 001");
        test_restart_phase();
        test_midbit_change();
        test_disable();
        test_gated_base();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule